// File: doc/BRIEF.md
# In-Band Flow Control Engine

This block adds automatic software (in-band) flow control to one serial channel. On the receive side it watches each character coming out of the deserializer. When it sees the programmed "stop" character, or a two-character stop sequence, it holds off the local transmitter and raises a suspend flag that the interrupt-status logic can show. The flag stays up until the "go" character, or sequence, arrives. Matched control characters are marked for discard, so the receive FIFO never stores them.

On the transmit side it compares the receive FIFO fill against its trigger threshold. It asks the transmitter to insert the stop character(s) once when the fill reaches the threshold. It asks for the go character(s) once the fill drops back below, but only after a stop was actually sent. The request is a level that carries the character and waits for an acknowledge. The transmitter sends inserted characters ahead of FIFO data, even while it is suspended, once the character in flight has finished.

Four 8-bit control characters and a 4-bit mode field are kept behind a key. Writes land, and reads return data, only while the line-control value presented to the block equals 0xBF.

Top module: `flow_ctl_top`

## Requirements
- R1: After reset the four control characters and the mode field read as 0, `tx_suspend` is 0 and `ins_req` is 0.
- R2: Configuration map on `cfg_addr`: 0 = mode (bits 1:0 receive mode, bits 3:2 transmit mode, bits 7:4 read as 0), 1 = go char 1, 2 = go char 2, 3 = stop char 1, 4 = stop char 2. A write while `lcr_value` is not 0xBF is ignored, and a read returns 0 unless `lcr_value` is 0xBF.
- R3: Receive mode 01 compares against char 1 and mode 10 against char 2. A received stop character sets `rx_drop` in the same cycle as `rx_valid`, and `tx_suspend` is 1 from the next cycle. A stop character that arrives while already suspended is also dropped.
- R4: While suspended, a received go character sets `rx_drop` and clears `tx_suspend` in the next cycle. A go character that arrives while not suspended is passed through (`rx_drop`=0) and has no effect.
- R5: Receive mode 11 requires char 1 immediately followed by char 2, counting received characters. Any other character in between restarts the search. The first character of a pair is passed through and only the completing character is dropped.
- R6: Receive mode 00 disables matching: no character is dropped and `tx_suspend` does not change.
- R7: With a non-zero transmit mode, when `fifo_count` >= `trig_level` and no stop is outstanding, `ins_req` rises the next cycle. The stop sequence is char 1 only (mode 01), char 2 only (10), or char 1 then char 2 (11).
- R8: A stop sequence is sent at most once per threshold crossing. While the fill stays at or above the threshold, no further request is made.
- R9: After a stop has been sent, a fill below `trig_level` triggers the go sequence in the same order. No go is requested unless a stop was sent before.
- R10: `ins_req` holds with a stable `ins_char` until `ins_ack`, whatever the state of `tx_suspend`. Each acknowledge advances to the next character or ends the sequence.
- R11: If a character equals both the stop and go value, it resumes when suspended and suspends otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcr_value | input | 8 | Current line-control value; 0xBF unlocks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_drop | output | 1 | Current received character is a consumed control character |
| tx_suspend | output | 1 | Transmitter hold-off and status flag |
| fifo_count | input | 6 | Receive FIFO fill level |
| trig_level | input | 6 | Receive FIFO trigger threshold |
| ins_req | output | 1 | Request to insert a control character |
| ins_char | output | 8 | Character to insert |
| ins_ack | input | 1 | Transmitter has taken `ins_char` |

## Verification
The receive matcher is fed plain data, bare go characters while running, repeated stop characters while suspended, correct pairs, and pairs broken by a stray character. This separates a matcher that counts characters from one that ignores ordering, and a flag that toggles from one that only sets. A stop character equal to the go character shows the priority chosen by the suspend state. The transmit side sweeps the fill level across the threshold and holds it on each side. Requests are held without acknowledge, so repeated sends, go requests without a prior stop, wrong sequence order and a request that drops early each show up at the ports.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;

    localparam int CFG_AW = 3;

    localparam logic [CFG_AW-1:0] ADR_MODE  = 3'd0;
    localparam logic [CFG_AW-1:0] ADR_GO1   = 3'd1;
    localparam logic [CFG_AW-1:0] ADR_GO2   = 3'd2;
    localparam logic [CFG_AW-1:0] ADR_STOP1 = 3'd3;
    localparam logic [CFG_AW-1:0] ADR_STOP2 = 3'd4;

    // compare / insert selection per direction
    typedef enum logic [1:0] {
        FM_OFF   = 2'b00,
        FM_CHAR1 = 2'b01,
        FM_CHAR2 = 2'b10,
        FM_PAIR  = 2'b11
    } fmode_e;

    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,
        TS_FIRST  = 2'd1,
        TS_SECOND = 2'd2
    } tstate_e;

endpackage

// File: rtl/flow_cfg_regs.sv
module flow_cfg_regs
    import flow_ctl_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  LOCK_KEY = 8'hBF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           lcr_value,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    output fmode_e               rx_mode,
    output fmode_e               tx_mode,
    output logic [DATA_W-1:0]    go1,
    output logic [DATA_W-1:0]    go2,
    output logic [DATA_W-1:0]    stop1,
    output logic [DATA_W-1:0]    stop2
);

    localparam int MODE_W = 4;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DATA_W-1:0] go1;
        logic [DATA_W-1:0] go2;
        logic [DATA_W-1:0] stop1;
        logic [DATA_W-1:0] stop2;
    } cfg_t;

    cfg_t st_d, st_q;
    logic unlocked;

    assign unlocked = (lcr_value == LOCK_KEY);

    always_comb begin
        st_d = st_q;
        if (cfg_we && unlocked) begin
            case (cfg_addr)
                ADR_MODE:  st_d.mode  = cfg_wdata[MODE_W-1:0];
                ADR_GO1:   st_d.go1   = cfg_wdata;
                ADR_GO2:   st_d.go2   = cfg_wdata;
                ADR_STOP1: st_d.stop1 = cfg_wdata;
                ADR_STOP2: st_d.stop2 = cfg_wdata;
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (unlocked) begin
            case (cfg_addr)
                ADR_MODE:  cfg_rdata = {{(DATA_W-MODE_W){1'b0}}, st_q.mode};
                ADR_GO1:   cfg_rdata = st_q.go1;
                ADR_GO2:   cfg_rdata = st_q.go2;
                ADR_STOP1: cfg_rdata = st_q.stop1;
                ADR_STOP2: cfg_rdata = st_q.stop2;
                default:   cfg_rdata = '0;
            endcase
        end
    end

    assign rx_mode = fmode_e'(st_q.mode[1:0]);
    assign tx_mode = fmode_e'(st_q.mode[3:2]);
    assign go1     = st_q.go1;
    assign go2     = st_q.go2;
    assign stop1   = st_q.stop1;
    assign stop2   = st_q.stop2;

endmodule

// File: rtl/flow_rx_match.sv
module flow_rx_match
    import flow_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmode_e            rx_mode,
    input  logic [DATA_W-1:0] go1,
    input  logic [DATA_W-1:0] go2,
    input  logic [DATA_W-1:0] stop1,
    input  logic [DATA_W-1:0] stop2,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_drop,
    output logic              suspend
);

    typedef struct packed {
        logic suspend;
        logic half_stop;   // first char of a stop pair seen last
        logic half_go;     // first char of a go pair seen last
    } rxm_t;

    rxm_t st_d, st_q;
    logic stop_hit, go_hit;

    always_comb begin
        stop_hit = 1'b0;
        go_hit   = 1'b0;
        case (rx_mode)
            FM_CHAR1: begin
                stop_hit = (rx_data == stop1);
                go_hit   = (rx_data == go1);
            end
            FM_CHAR2: begin
                stop_hit = (rx_data == stop2);
                go_hit   = (rx_data == go2);
            end
            FM_PAIR: begin
                stop_hit = st_q.half_stop && (rx_data == stop2);
                go_hit   = st_q.half_go   && (rx_data == go2);
            end
            default: begin
                stop_hit = 1'b0;
                go_hit   = 1'b0;
            end
        endcase
    end

    always_comb begin
        st_d    = st_q;
        rx_drop = 1'b0;
        if (rx_mode == FM_OFF) begin
            st_d.half_stop = 1'b0;
            st_d.half_go   = 1'b0;
        end else if (rx_valid) begin
            if (st_q.suspend && go_hit) begin
                st_d.suspend   = 1'b0;
                st_d.half_stop = 1'b0;
                st_d.half_go   = 1'b0;
                rx_drop        = 1'b1;
            end else if (stop_hit) begin
                st_d.suspend   = 1'b1;
                st_d.half_stop = 1'b0;
                st_d.half_go   = 1'b0;
                rx_drop        = 1'b1;
            end else begin
                st_d.half_stop = (rx_mode == FM_PAIR) && (rx_data == stop1);
                st_d.half_go   = (rx_mode == FM_PAIR) && (rx_data == go1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign suspend = st_q.suspend;

endmodule

// File: rtl/flow_tx_insert.sv
module flow_tx_insert
    import flow_ctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmode_e            tx_mode,
    input  logic [DATA_W-1:0] go1,
    input  logic [DATA_W-1:0] go2,
    input  logic [DATA_W-1:0] stop1,
    input  logic [DATA_W-1:0] stop2,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              ins_ack,
    output logic              ins_req,
    output logic [DATA_W-1:0] ins_char
);

    typedef struct packed {
        tstate_e state;
        logic    is_stop;    // sequence in progress is a stop
        logic    stop_sent;  // stop went out, go still owed
    } txi_t;

    txi_t st_d, st_q;
    logic above;

    assign above = (fifo_count >= trig_level);

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            TS_IDLE: begin
                if (tx_mode != FM_OFF) begin
                    if (above && !st_q.stop_sent) begin
                        st_d.is_stop = 1'b1;
                        st_d.state   = (tx_mode == FM_CHAR2) ? TS_SECOND : TS_FIRST;
                    end else if (!above && st_q.stop_sent) begin
                        st_d.is_stop = 1'b0;
                        st_d.state   = (tx_mode == FM_CHAR2) ? TS_SECOND : TS_FIRST;
                    end
                end
            end
            TS_FIRST: begin
                if (ins_ack) begin
                    if (tx_mode == FM_PAIR) begin
                        st_d.state = TS_SECOND;
                    end else begin
                        st_d.state     = TS_IDLE;
                        st_d.stop_sent = st_q.is_stop;
                    end
                end
            end
            TS_SECOND: begin
                if (ins_ack) begin
                    st_d.state     = TS_IDLE;
                    st_d.stop_sent = st_q.is_stop;
                end
            end
            default: st_d.state = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: TS_IDLE, is_stop: 1'b0, stop_sent: 1'b0};
        else        st_q <= st_d;
    end

    assign ins_req = (st_q.state != TS_IDLE);

    always_comb begin
        if (st_q.state == TS_SECOND) ins_char = st_q.is_stop ? stop2 : go2;
        else                         ins_char = st_q.is_stop ? stop1 : go1;
    end

endmodule

// File: rtl/flow_ctl_top.sv
module flow_ctl_top
    import flow_ctl_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         FIFO_DEPTH = 32,
    parameter logic [7:0] LOCK_KEY   = 8'hBF,
    localparam int        CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        lcr_value,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_drop,
    output logic              tx_suspend,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [CNT_W-1:0]  trig_level,
    output logic              ins_req,
    output logic [DATA_W-1:0] ins_char,
    input  logic              ins_ack
);

    fmode_e            rx_mode, tx_mode;
    logic [DATA_W-1:0] go1, go2, stop1, stop2;

    flow_cfg_regs #(.DATA_W(DATA_W), .LOCK_KEY(LOCK_KEY)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lcr_value (lcr_value),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .rx_mode   (rx_mode),
        .tx_mode   (tx_mode),
        .go1       (go1),
        .go2       (go2),
        .stop1     (stop1),
        .stop2     (stop2)
    );

    flow_rx_match #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_mode  (rx_mode),
        .go1      (go1),
        .go2      (go2),
        .stop1    (stop1),
        .stop2    (stop2),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_drop  (rx_drop),
        .suspend  (tx_suspend)
    );

    flow_tx_insert #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_mode    (tx_mode),
        .go1        (go1),
        .go2        (go2),
        .stop1      (stop1),
        .stop2      (stop2),
        .fifo_count (fifo_count),
        .trig_level (trig_level),
        .ins_ack    (ins_ack),
        .ins_req    (ins_req),
        .ins_char   (ins_char)
    );

endmodule

// File: rtl/flow_ctl_checker.sv
module flow_ctl_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_drop,
    input logic              tx_suspend,
    input logic              ins_req,
    input logic              ins_ack,
    input logic [DATA_W-1:0] ins_char
);

    assert_drop_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> rx_valid);

    assert_stop_sets_suspend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_drop && !tx_suspend) |=> tx_suspend);

    assert_suspend_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_suspend) |-> $past(rx_valid && rx_drop));

    assert_suspend_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_suspend) |-> $past(rx_valid && rx_drop));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack) |=> (ins_req && $stable(ins_char)));

endmodule

bind flow_ctl_top flow_ctl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_drop    (rx_drop),
    .tx_suspend (tx_suspend),
    .ins_req    (ins_req),
    .ins_ack    (ins_ack),
    .ins_char   (ins_char)
);

// File: tb/flow_ctl_top_tb.sv
module flow_ctl_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lcr_value = 8'h00;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_drop;
    logic       tx_suspend;
    logic [5:0] fifo_count = 6'd0;
    logic [5:0] trig_level = 6'd16;
    logic       ins_req;
    logic [7:0] ins_char;
    logic       ins_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flow_ctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .lcr_value(lcr_value),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_drop(rx_drop), .tx_suspend(tx_suspend), .fifo_count(fifo_count),
        .trig_level(trig_level), .ins_req(ins_req), .ins_char(ins_char),
        .ins_ack(ins_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic rx_char(input string req, input logic [7:0] c,
                           input logic exp_drop, input logic exp_susp);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = c;
        #1 chk({req, " drop"}, rx_drop, exp_drop);
        @(posedge clk); #1;
        chk({req, " suspend"}, tx_suspend, exp_susp);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic set_count(input logic [5:0] n);
        @(negedge clk);
        fifo_count = n;
        @(posedge clk); #1;
    endtask

    task automatic ack_one;
        @(negedge clk);
        ins_ack = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        ins_ack = 1'b0;
    endtask

    task automatic program_chars;
        lcr_value = 8'hBF;
        cfg_write(3'd1, 8'h11);
        cfg_write(3'd2, 8'h91);
        cfg_write(3'd3, 8'h13);
        cfg_write(3'd4, 8'h93);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        lcr_value = 8'hBF;
        for (int a = 0; a < 5; a++) begin
            cfg_read(3'(a), d);
            chk("R1 cfg reset", d, 8'h00);
        end
        chk("R1 suspend reset", tx_suspend, 1'b0);
        chk("R1 req reset", ins_req, 1'b0);
    endtask

    task automatic t_lock;
        logic [7:0] d;
        lcr_value = 8'h03;
        cfg_write(3'd3, 8'h13);
        lcr_value = 8'hBF;
        cfg_read(3'd3, d);
        chk("R2 locked write ignored", d, 8'h00);
        cfg_write(3'd0, 8'hFF);
        cfg_read(3'd0, d);
        chk("R2 mode upper bits", d, 8'h0F);
        lcr_value = 8'h03;
        cfg_read(3'd0, d);
        chk("R2 locked read zero", d, 8'h00);
        lcr_value = 8'hBF;
        cfg_write(3'd0, 8'h00);
    endtask

    task automatic t_single1;
        program_chars();
        cfg_write(3'd0, 8'h01);
        rx_char("R3 plain data", 8'h41, 1'b0, 1'b0);
        rx_char("R4 go while running", 8'h11, 1'b0, 1'b0);
        rx_char("R3 stop char1", 8'h13, 1'b1, 1'b1);
        rx_char("R3 stop again", 8'h13, 1'b1, 1'b1);
        rx_char("R4 go resumes", 8'h11, 1'b1, 1'b0);
    endtask

    task automatic t_single2;
        cfg_write(3'd0, 8'h02);
        rx_char("R3 char1 ignored in mode 10", 8'h13, 1'b0, 1'b0);
        rx_char("R3 stop char2", 8'h93, 1'b1, 1'b1);
        rx_char("R4 go char2", 8'h91, 1'b1, 1'b0);
    endtask

    task automatic t_pair;
        cfg_write(3'd0, 8'h03);
        rx_char("R5 pair first", 8'h13, 1'b0, 1'b0);
        rx_char("R5 intruder", 8'h41, 1'b0, 1'b0);
        rx_char("R5 broken pair", 8'h93, 1'b0, 1'b0);
        rx_char("R5 pair first again", 8'h13, 1'b0, 1'b0);
        rx_char("R5 pair complete", 8'h93, 1'b1, 1'b1);
        rx_char("R5 go first", 8'h11, 1'b0, 1'b1);
        rx_char("R5 go complete", 8'h91, 1'b1, 1'b0);
    endtask

    task automatic t_off;
        cfg_write(3'd0, 8'h00);
        rx_char("R6 stop ignored", 8'h13, 1'b0, 1'b0);
        rx_char("R6 stop2 ignored", 8'h93, 1'b0, 1'b0);
    endtask

    task automatic t_same_char;
        cfg_write(3'd1, 8'h55);
        cfg_write(3'd3, 8'h55);
        cfg_write(3'd0, 8'h01);
        rx_char("R11 shared suspends", 8'h55, 1'b1, 1'b1);
        rx_char("R11 shared resumes", 8'h55, 1'b1, 1'b0);
        program_chars();
    endtask

    task automatic t_tx_pair;
        // receive mode 01, transmit mode 11
        cfg_write(3'd0, 8'h0D);
        set_count(6'd5);
        set_count(6'd5);
        chk("R9 no go without stop", ins_req, 1'b0);
        rx_char("R10 suspend first", 8'h13, 1'b1, 1'b1);
        set_count(6'd20);
        chk("R7 stop request", ins_req, 1'b1);
        chk("R7 stop char1", ins_char, 8'h13);
        set_count(6'd20);
        set_count(6'd20);
        chk("R10 held while suspended", ins_req, 1'b1);
        chk("R10 char stable", ins_char, 8'h13);
        ack_one();
        chk("R7 stop char2", ins_char, 8'h93);
        chk("R10 still req", ins_req, 1'b1);
        ack_one();
        chk("R7 sequence done", ins_req, 1'b0);
        set_count(6'd30);
        set_count(6'd16);
        set_count(6'd16);
        chk("R8 once per crossing", ins_req, 1'b0);
        set_count(6'd15);
        chk("R9 go request", ins_req, 1'b1);
        chk("R9 go char1", ins_char, 8'h11);
        ack_one();
        chk("R9 go char2", ins_char, 8'h91);
        ack_one();
        chk("R9 go done", ins_req, 1'b0);
        set_count(6'd2);
        set_count(6'd2);
        chk("R9 single go", ins_req, 1'b0);
        rx_char("R4 resume", 8'h11, 1'b1, 1'b0);
    endtask

    task automatic t_tx_single;
        cfg_write(3'd0, 8'h08);
        set_count(6'd16);
        chk("R7 mode10 req", ins_req, 1'b1);
        chk("R7 mode10 char", ins_char, 8'h93);
        ack_one();
        chk("R7 mode10 done", ins_req, 1'b0);
        set_count(6'd3);
        chk("R9 mode10 go char", ins_char, 8'h91);
        ack_one();
        chk("R9 mode10 done", ins_req, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_single1();
        t_single2();
        t_pair();
        t_off();
        t_same_char();
        t_tx_pair();
        t_tx_single();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule